// File: doc/BRIEF.md
# Quantized Double-Correlation Preamble Metric

This block turns a complex baseband stream, one sample per symbol, into a frame-detection score with one value per accepted sample. For every lag m from 1 to `MAX_LAG` it multiplies each received sample by the conjugate of the sample m symbols earlier. It correlates the resulting lagged products, over the most recent `N_PRE` positions, against fixed coefficients derived from the known preamble. The per-lag correlations are reduced to |Re|+|Im| and added together. A later stage compares the score with a threshold and searches for the peak; that stage lies outside this block.

The preamble is held as two sign bits per symbol, so each symbol is one of the four corners (±1±j). A coefficient is then a product of two such corners: one component is ±2 and the other is 0. Weighting therefore needs only shift, negate and add. True multipliers appear only in the lagged-product stage, one complex multiplier per lag. Both products are unaffected by a constant carrier phase, so the score is too.

Top module: `qdc_metric`

## Requirements
- R1: While reset is asserted, and at release, `metric_valid` is 0 and `metric` is 0.
- R2: For the accepted sample of index n, `metric` equals the sum over m=1..MAX_LAG of |Re S_m|+|Im S_m|. Here S_m = Σ_{k=m}^{N_PRE-1} r[n-N_PRE+1+k]·conj(r[n-N_PRE+1+k-m])·conj(q[k])·q[k-m], and symbol q[k] = (PREAMBLE[2k] ? -1 : +1) + j(PREAMBLE[2k+1] ? -1 : +1). Symbol 0 is the earliest of the preamble.
- R3: A sample accepted at clock edge E produces its metric, with `metric_valid` high for exactly one cycle, after edge E+2.
- R4: `metric_valid` stays low for the first N_PRE+MAX_LAG-1 samples accepted after reset and first rises for sample number N_PRE+MAX_LAG.
- R5: Cycles with `sample_valid` low neither advance the sample history nor produce `metric_valid`. Samples around a gap give the same metrics as the same samples sent back to back.
- R6: Full-scale inputs (every component at the most negative or most positive code) give exact metrics with no wrap-around.
- R7: When the last N_PRE samples equal A·q[k] exactly, the metric equals 4·A²·Σ_{m=1..MAX_LAG}(N_PRE-m).
- R8: Asserting reset in the middle of a stream clears the fill state, and R4 then applies again from the next accepted sample.
- R9: Multiplying every sample by j leaves the metric unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | A sample is presented this cycle |
| sample_i | input | SAMPLE_W | Signed in-phase component |
| sample_q | input | SAMPLE_W | Signed quadrature component |
| metric_valid | output | 1 | `metric` carries a score for a filled window |
| metric | output | METRIC_W | Unsigned detection score |

## Verification
The bench builds the block with 8-bit samples, an 8-symbol preamble and a maximum lag of 3. This keeps the reference sums small enough to compute directly for every single sample. In this configuration the fill boundary falls at sample 11, so it is crossed many times. Extreme-code streams reach the widest accumulator values. Both an aligned preamble and a phase-rotated preamble give a known closed-form score. Random gaps in the valid stream and a reset in the middle of a stream exercise the history and fill logic against the same arithmetic model.

// File: rtl/qdc_pkg.sv
package qdc_pkg;

  // Quantized coefficient: each component holds -2..+2
  typedef struct packed {
    logic signed [2:0] re;
    logic signed [2:0] im;
  } qcoef_t;

  // conj(a) * b for two corner symbols given as sign bits (1 = negative)
  function automatic qcoef_t corner_conj_prod(input logic a_i_neg, input logic a_q_neg,
                                              input logic b_i_neg, input logic b_q_neg);
    int ai, aq, bi, bq;
    qcoef_t c;
    ai = a_i_neg ? -1 : 1;
    aq = a_q_neg ? -1 : 1;
    bi = b_i_neg ? -1 : 1;
    bq = b_q_neg ? -1 : 1;
    c.re = 3'(ai * bi + aq * bq);
    c.im = 3'(ai * bq - aq * bi);
    return c;
  endfunction

endpackage

// File: rtl/qdc_lag_product.sv
module qdc_lag_product #(
  parameter int SAMPLE_W = 12,
  parameter int MAX_LAG  = 4,
  parameter int PROD_W   = 2 * SAMPLE_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_en,
  input  logic signed [SAMPLE_W-1:0] in_i,
  input  logic signed [SAMPLE_W-1:0] in_q,
  output logic signed [PROD_W-1:0]   prod_re [MAX_LAG],
  output logic signed [PROD_W-1:0]   prod_im [MAX_LAG]
);

  // hist_*[l] holds the sample l+1 symbols before the current one
  logic signed [SAMPLE_W-1:0] hist_i     [MAX_LAG];
  logic signed [SAMPLE_W-1:0] hist_q     [MAX_LAG];
  logic signed [SAMPLE_W-1:0] hist_i_nxt [MAX_LAG];
  logic signed [SAMPLE_W-1:0] hist_q_nxt [MAX_LAG];

  always_comb begin
    for (int l = 0; l < MAX_LAG; l++) begin
      hist_i_nxt[l] = hist_i[l];
      hist_q_nxt[l] = hist_q[l];
    end
    if (in_en) begin
      hist_i_nxt[0] = in_i;
      hist_q_nxt[0] = in_q;
      for (int l = 1; l < MAX_LAG; l++) begin
        hist_i_nxt[l] = hist_i[l-1];
        hist_q_nxt[l] = hist_q[l-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < MAX_LAG; l++) begin
        hist_i[l] <= '0;
        hist_q[l] <= '0;
      end
    end else begin
      for (int l = 0; l < MAX_LAG; l++) begin
        hist_i[l] <= hist_i_nxt[l];
        hist_q[l] <= hist_q_nxt[l];
      end
    end
  end

  // One complex multiplier per lag: r[n] * conj(r[n-lag])
  for (genvar l = 0; l < MAX_LAG; l++) begin : g_lag
    logic signed [PROD_W-1:0] xr, xi, yr, yi;
    always_comb begin
      xr = PROD_W'(in_i);
      xi = PROD_W'(in_q);
      yr = PROD_W'(hist_i[l]);
      yi = PROD_W'(hist_q[l]);
      prod_re[l] = xr * yr + xi * yi;
      prod_im[l] = xi * yr - xr * yi;
    end
  end

endmodule

// File: rtl/qdc_lag_corr.sv
module qdc_lag_corr
  import qdc_pkg::*;
#(
  parameter int                  PROD_W   = 25,
  parameter int                  N_PRE    = 32,
  parameter int                  LAG      = 1,
  parameter logic [2*N_PRE-1:0]  PREAMBLE = '0,
  parameter int                  CORR_W   = PROD_W + 2 + $clog2(N_PRE)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic                     load_en,
  input  logic signed [PROD_W-1:0] d_re,
  input  logic signed [PROD_W-1:0] d_im,
  output logic signed [CORR_W-1:0] corr_re,
  output logic signed [CORR_W-1:0] corr_im
);

  localparam int WT_W = PROD_W + 2;

  // Coefficient for preamble position k at this lag; zero where k-LAG < 0
  function automatic qcoef_t coef_at(input int k);
    qcoef_t c;
    c = '0;
    if (k >= LAG)
      c = corner_conj_prod(PREAMBLE[2*k], PREAMBLE[2*k+1],
                           PREAMBLE[2*(k-LAG)], PREAMBLE[2*(k-LAG)+1]);
    return c;
  endfunction

  // Multiply by a value in -2..+2 with shift and negate only
  function automatic logic signed [WT_W-1:0] shift_weight(input logic signed [PROD_W-1:0] x,
                                                          input logic signed [2:0] c);
    logic signed [WT_W-1:0] xe;
    logic signed [WT_W-1:0] r;
    xe = WT_W'(x);
    case (c)
      3'sb001: r = xe;
      3'sb111: r = -xe;
      3'sb010: r = xe <<< 1;
      3'sb110: r = -(xe <<< 1);
      default: r = '0;
    endcase
    return r;
  endfunction

  // Delay line of lagged products: line_re[0] newest (preamble position N_PRE-1)
  logic signed [PROD_W-1:0] line_re     [N_PRE];
  logic signed [PROD_W-1:0] line_im     [N_PRE];
  logic signed [PROD_W-1:0] line_re_nxt [N_PRE];
  logic signed [PROD_W-1:0] line_im_nxt [N_PRE];

  always_comb begin
    for (int p = 0; p < N_PRE; p++) begin
      line_re_nxt[p] = line_re[p];
      line_im_nxt[p] = line_im[p];
    end
    if (shift_en) begin
      line_re_nxt[0] = d_re;
      line_im_nxt[0] = d_im;
      for (int p = 1; p < N_PRE; p++) begin
        line_re_nxt[p] = line_re[p-1];
        line_im_nxt[p] = line_im[p-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < N_PRE; p++) begin
        line_re[p] <= '0;
        line_im[p] <= '0;
      end
    end else begin
      for (int p = 0; p < N_PRE; p++) begin
        line_re[p] <= line_re_nxt[p];
        line_im[p] <= line_im_nxt[p];
      end
    end
  end

  // Weighted terms, one per preamble position
  logic signed [WT_W-1:0] term_re [N_PRE];
  logic signed [WT_W-1:0] term_im [N_PRE];

  for (genvar k = 0; k < N_PRE; k++) begin : g_pos
    localparam qcoef_t C = coef_at(k);
    always_comb begin
      term_re[k] = shift_weight(line_re[N_PRE-1-k], C.re) - shift_weight(line_im[N_PRE-1-k], C.im);
      term_im[k] = shift_weight(line_re[N_PRE-1-k], C.im) + shift_weight(line_im[N_PRE-1-k], C.re);
    end
  end

  logic signed [CORR_W-1:0] sum_re, sum_im;

  always_comb begin
    sum_re = '0;
    sum_im = '0;
    for (int k = 0; k < N_PRE; k++) begin
      sum_re = sum_re + CORR_W'(term_re[k]);
      sum_im = sum_im + CORR_W'(term_im[k]);
    end
  end

  logic signed [CORR_W-1:0] corr_re_nxt, corr_im_nxt;

  always_comb begin
    corr_re_nxt = corr_re;
    corr_im_nxt = corr_im;
    if (load_en) begin
      corr_re_nxt = sum_re;
      corr_im_nxt = sum_im;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_re <= '0;
      corr_im <= '0;
    end else begin
      corr_re <= corr_re_nxt;
      corr_im <= corr_im_nxt;
    end
  end

endmodule

// File: rtl/qdc_mag_sum.sv
module qdc_mag_sum #(
  parameter int CORR_W   = 32,
  parameter int MAX_LAG  = 4,
  parameter int METRIC_W = CORR_W + 1 + $clog2(MAX_LAG + 1)
) (
  input  logic signed [CORR_W-1:0] corr_re [MAX_LAG],
  input  logic signed [CORR_W-1:0] corr_im [MAX_LAG],
  output logic        [METRIC_W-1:0] total
);

  localparam int MAG_W = CORR_W + 1;

  logic [MAG_W-1:0] mag [MAX_LAG];

  for (genvar l = 0; l < MAX_LAG; l++) begin : g_mag
    logic [CORR_W-1:0] abs_re, abs_im;
    always_comb begin
      abs_re = corr_re[l][CORR_W-1] ? CORR_W'(-corr_re[l]) : CORR_W'(corr_re[l]);
      abs_im = corr_im[l][CORR_W-1] ? CORR_W'(-corr_im[l]) : CORR_W'(corr_im[l]);
      mag[l] = MAG_W'(abs_re) + MAG_W'(abs_im);
    end
  end

  always_comb begin
    total = '0;
    for (int l = 0; l < MAX_LAG; l++)
      total = total + METRIC_W'(mag[l]);
  end

endmodule

// File: rtl/qdc_metric.sv
module qdc_metric
  import qdc_pkg::*;
#(
  parameter int                 SAMPLE_W = 12,
  parameter int                 N_PRE    = 32,
  parameter int                 MAX_LAG  = 4,
  parameter logic [2*N_PRE-1:0] PREAMBLE = 64'hB1E4_7A3C_2D95_0F68,
  localparam int PROD_W   = 2 * SAMPLE_W + 1,
  localparam int CORR_W   = PROD_W + 2 + $clog2(N_PRE),
  localparam int METRIC_W = CORR_W + 1 + $clog2(MAX_LAG + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sample_valid,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic signed [SAMPLE_W-1:0] sample_q,
  output logic                       metric_valid,
  output logic [METRIC_W-1:0]        metric
);

  localparam int FILL  = N_PRE + MAX_LAG;
  localparam int CNT_W = $clog2(FILL + 1);

  // Fill tracking and valid pipeline
  logic [CNT_W-1:0] fill_cnt, fill_cnt_nxt;
  logic             full_now;
  logic             v1, v2, f1, f2;
  logic             metric_valid_nxt;

  assign full_now = (fill_cnt >= CNT_W'(FILL - 1));

  always_comb begin
    fill_cnt_nxt = fill_cnt;
    if (sample_valid && !full_now)
      fill_cnt_nxt = fill_cnt + 1'b1;
    metric_valid_nxt = v2 & f2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt     <= '0;
      v1           <= 1'b0;
      f1           <= 1'b0;
      v2           <= 1'b0;
      f2           <= 1'b0;
      metric_valid <= 1'b0;
    end else begin
      fill_cnt     <= fill_cnt_nxt;
      v1           <= sample_valid;
      f1           <= sample_valid & full_now;
      v2           <= v1;
      f2           <= f1;
      metric_valid <= metric_valid_nxt;
    end
  end

  // Lagged products
  logic signed [PROD_W-1:0] prod_re [MAX_LAG];
  logic signed [PROD_W-1:0] prod_im [MAX_LAG];

  qdc_lag_product #(
    .SAMPLE_W (SAMPLE_W),
    .MAX_LAG  (MAX_LAG),
    .PROD_W   (PROD_W)
  ) u_prod (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_en   (sample_valid),
    .in_i    (sample_i),
    .in_q    (sample_q),
    .prod_re (prod_re),
    .prod_im (prod_im)
  );

  // Per-lag correlators
  logic signed [CORR_W-1:0] corr_re [MAX_LAG];
  logic signed [CORR_W-1:0] corr_im [MAX_LAG];

  for (genvar l = 0; l < MAX_LAG; l++) begin : g_corr
    qdc_lag_corr #(
      .PROD_W   (PROD_W),
      .N_PRE    (N_PRE),
      .LAG      (l + 1),
      .PREAMBLE (PREAMBLE),
      .CORR_W   (CORR_W)
    ) u_corr (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (sample_valid),
      .load_en  (v1),
      .d_re     (prod_re[l]),
      .d_im     (prod_im[l]),
      .corr_re  (corr_re[l]),
      .corr_im  (corr_im[l])
    );
  end

  // Magnitude combine and output register
  logic [METRIC_W-1:0] total, metric_nxt;

  qdc_mag_sum #(
    .CORR_W   (CORR_W),
    .MAX_LAG  (MAX_LAG),
    .METRIC_W (METRIC_W)
  ) u_mag (
    .corr_re (corr_re),
    .corr_im (corr_im),
    .total   (total)
  );

  always_comb begin
    metric_nxt = metric;
    if (v2)
      metric_nxt = total;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      metric <= '0;
    else
      metric <= metric_nxt;
  end

endmodule

// File: rtl/qdc_metric_chk.sv
module qdc_metric_chk #(
  parameter int FILL     = 36,
  parameter int METRIC_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sample_valid,
  input logic                metric_valid,
  input logic [METRIC_W-1:0] metric
);

  localparam int CNT_W = $clog2(FILL + 1);

  logic [CNT_W-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      seen <= '0;
    else if (sample_valid && seen < CNT_W'(FILL))
      seen <= seen + 1'b1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    metric_valid |-> $past(sample_valid, 3)); // R3

  AST_HOLD_ON_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sample_valid, 3) |-> $stable(metric)); // R5

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    metric_valid |-> (seen >= CNT_W'(FILL))); // R4

  AST_PULSE_PER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (metric_valid && !$past(sample_valid, 2)) |=> !metric_valid); // R3

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!metric_valid && metric == '0); // R1
    end
  end

endmodule

bind qdc_metric qdc_metric_chk #(
  .FILL     (N_PRE + MAX_LAG),
  .METRIC_W (METRIC_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_valid (sample_valid),
  .metric_valid (metric_valid),
  .metric       (metric)
);

// File: tb/test_qdc_metric.sv
module test_qdc_metric;

  localparam int          W   = 8;
  localparam int          N   = 8;
  localparam int          M   = 3;
  localparam logic [15:0] PRE = 16'h6C93;
  localparam int          MW  = (2*W+1) + 2 + $clog2(N) + 1 + $clog2(M+1);
  localparam int          A   = 100;
  localparam longint      ALIGNED = 4 * A * A * ((N-1) + (N-2) + (N-3));

  logic                clk;
  logic                rst_n;
  logic                sample_valid;
  logic signed [W-1:0] sample_i, sample_q;
  logic                metric_valid;
  logic [MW-1:0]       metric;

  qdc_metric #(
    .SAMPLE_W (W),
    .N_PRE    (N),
    .MAX_LAG  (M),
    .PREAMBLE (PRE)
  ) i_qdc_metric (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .sample_i     (sample_i),
    .sample_q     (sample_q),
    .metric_valid (metric_valid),
    .metric       (metric)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int     errors = 0;
  int     checks = 0;
  bit     done   = 0;
  string  cur_req = "R2";

  longint hr [0:4095];
  longint hq [0:4095];
  int     nsmp;

  bit     pv  [3];
  longint pm  [3];
  string  pr  [3];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int qs(input int bitpos);
    return PRE[bitpos] ? -1 : 1;
  endfunction

  function automatic longint absl(input longint x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic longint model(input int n);
    longint tot = 0;
    for (int m = 1; m <= M; m++) begin
      longint sr = 0;
      longint si = 0;
      for (int k = m; k < N; k++) begin
        int j  = n - N + 1 + k;
        int jp = j - m;
        longint dr = hr[j] * hr[jp] + hq[j] * hq[jp];
        longint di = hq[j] * hr[jp] - hr[j] * hq[jp];
        longint cr = qs(2*k) * qs(2*(k-m)) + qs(2*k+1) * qs(2*(k-m)+1);
        longint ci = qs(2*k) * qs(2*(k-m)+1) - qs(2*k+1) * qs(2*(k-m));
        sr += dr * cr - di * ci;
        si += dr * ci + di * cr;
      end
      tot += absl(sr) + absl(si);
    end
    return tot;
  endfunction

  task automatic clear_pipe();
    for (int p = 0; p < 3; p++) begin
      pv[p] = 0;
      pm[p] = 0;
      pr[p] = "R4";
    end
  endtask

  // One cycle: check the outcome of the sample driven three negedges ago, then drive
  task automatic step(input bit v, input int si, input int sq, input longint ovr);
    @(negedge clk);
    check(metric_valid === pv[2], "R3 R4 metric_valid", longint'(metric_valid), longint'(pv[2]));
    if (pv[2])
      check(longint'(metric) == pm[2], pr[2], longint'(metric), pm[2]);
    pv[2] = pv[1]; pm[2] = pm[1]; pr[2] = pr[1];
    pv[1] = pv[0]; pm[1] = pm[0]; pr[1] = pr[0];
    pv[0] = 0;     pm[0] = 0;     pr[0] = cur_req;
    sample_valid = v;
    sample_i     = W'(si);
    sample_q     = W'(sq);
    if (v) begin
      hr[nsmp] = si;
      hq[nsmp] = sq;
      if (nsmp >= N + M - 1) begin
        pv[0] = 1;
        pm[0] = (ovr >= 0) ? ovr : model(nsmp);
        if (ovr >= 0) begin
          // bench self-consistency of the closed form against the model
          check(model(nsmp) == ovr, cur_req, model(nsmp), ovr);
        end
      end
      nsmp++;
    end
  endtask

  function automatic int rnd_s();
    return int'($urandom_range(0, 255)) - 128;
  endfunction

  function automatic int ext_s();
    return ($urandom_range(0, 1) != 0) ? 127 : -128;
  endfunction

  task automatic flush();
    for (int c = 0; c < 4; c++) step(0, 0, 0, -1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b1;
    sample_valid = 1'b0;
    sample_i = '0;
    sample_q = '0;
    nsmp = 0;
    clear_pipe();
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(metric_valid === 1'b0, "R1 valid in reset", longint'(metric_valid), 0);
    check(metric == '0, "R1 metric in reset", longint'(metric), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(metric_valid === 1'b0 && metric == '0, "R1 after release", longint'(metric), 0);

    // R4 fill boundary and R2 random stream, back to back
    cur_req = "R2";
    for (int c = 0; c < 200; c++) step(1, rnd_s(), rnd_s(), -1);

    // R5: random gaps
    cur_req = "R5";
    for (int c = 0; c < 300; c++) begin
      if ($urandom_range(0, 2) == 0) step(0, rnd_s(), rnd_s(), -1);
      else                           step(1, rnd_s(), rnd_s(), -1);
    end

    // R6: full-scale codes, continuous and with gaps
    cur_req = "R6";
    for (int c = 0; c < 200; c++) step(1, ext_s(), ext_s(), -1);
    for (int c = 0; c < 60; c++) step(1, -128, -128, -1);
    for (int c = 0; c < 60; c++) step(($urandom_range(0, 1) != 0), ext_s(), -128, -1);

    // R7: noiseless aligned preamble, several repetitions after noise
    for (int rep = 0; rep < 4; rep++) begin
      cur_req = "R2";
      for (int c = 0; c < 5 + rep; c++) step(1, rnd_s(), rnd_s(), -1);
      cur_req = "R7";
      for (int k = 0; k < N; k++)
        step(1, A * qs(2*k), A * qs(2*k+1), (k == N-1) ? ALIGNED : -1);
    end

    // R9: preamble rotated by j gives the same score
    cur_req = "R9";
    for (int rep = 0; rep < 3; rep++) begin
      for (int k = 0; k < N; k++)
        step(1, -A * qs(2*k+1), A * qs(2*k), (k == N-1) ? ALIGNED : -1);
      step(0, 0, 0, -1);
    end
    flush();

    // R8: reset in the middle of a stream, then refill
    cur_req = "R8";
    for (int c = 0; c < 20; c++) step(1, rnd_s(), rnd_s(), -1);
    @(negedge clk);
    rst_n = 1'b0;
    sample_valid = 1'b0;
    nsmp = 0;
    clear_pipe();
    @(negedge clk);
    check(metric_valid === 1'b0, "R8 valid cleared by reset", longint'(metric_valid), 0);
    rst_n = 1'b1;
    for (int c = 0; c < 40; c++) step(1, rnd_s(), rnd_s(), -1);
    for (int c = 0; c < 40; c++) step(($urandom_range(0, 3) != 0), rnd_s(), rnd_s(), -1);
    flush();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule